// File: doc/BRIEF.md
# Conversion Trigger and Sequence Controller

This block decides when an analog-to-digital conversion sequence begins and which channels it visits. It sits between a set of control inputs and a conversion engine. Every start it issues is a one-cycle request carrying a channel number. The engine answers with a done pulse and a data word. The block files each answer into one of eight result slots, and each slot has its own completion flag. When the last slot of a sequence is filled, the block raises a sequence-complete flag and, if enabled, an interrupt.

A sequence can start in two ways. With the trigger disabled, a write of the sequence word starts it. With the trigger enabled, events on an external trigger pin start it. The pin modes are a falling edge, a rising edge, an active-low level or an active-high level. A sequence either repeats one channel or steps through consecutive channel codes. It can also run again and again in scan mode until it is stopped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `cc_flags`, `seq_done`, `irq` and `conv_start` are all 0.
- R2: With `trig_en`=0 and `power_up`=1, a `seq_wr` sampled at a clock edge puts `conv_start` high for exactly one cycle, starting right after that edge.
- R3: `len_sel` sets the sequence length: 2'b00 gives 4 conversions, 2'b01 gives 1, and 2'b10 or 2'b11 gives 8. Conversion k of a sequence fills slot k and sets bit k of `cc_flags`.
- R4: With `seq_multi`=0, every conversion uses `seq_chan`. With `seq_multi`=1, conversion k uses (`seq_chan`+k) mod 16.
- R5: A channel code of `NUM_CH` (12) or above stores 0 in its slot, whatever the engine returns. Its flag is still set and no error indication exists.
- R6: With `trig_en`=1, `seq_wr` records the sequence settings but starts nothing.
- R7: With `trig_en`=1 and `trig_level`=0, a pin edge of the polarity that `trig_pol` selects starts exactly one sequence (0 selects falling, 1 selects rising). The opposite edge starts nothing. `conv_start` rises in the third cycle after the pin changes.
- R8: With `trig_en`=1 and `trig_level`=1, sequences run back to back while the pin is at the level that `trig_pol` selects (0 selects low, 1 selects high). They stop once the pin has left that level.
- R9: With `seq_scan`=1 and the trigger off, sequences repeat until one of four things happens: a non-scan write, a `halt_req` pulse, `power_up`=0 or `soft_rst`.
- R10: A write or trigger start clears all flags and `seq_done`. `seq_done` sets when the last slot is filled. With `fast_clr`=1, a read strobe (`rd_en`) clears the flag of slot `rd_slot`. With `fast_clr`=0, a read strobe leaves the flags as they are.
- R11: `irq` is high exactly when `seq_done` is 1 and `irq_en` is 1.
- R12: While `power_up`=0, no conversion starts and any running activity stops. Results and flags keep their values, and raising `power_up` again does not clear them.
- R13: `soft_rst` stops all activity and clears results, flags and `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| power_up | input | 1 | Module enable; 0 powers the block down |
| halt_req | input | 1 | Wait/stop request; aborts activity |
| soft_rst | input | 1 | Test-register module reset |
| trig_en | input | 1 | External trigger enable |
| trig_level | input | 1 | 0 = edge mode, 1 = level mode |
| trig_pol | input | 1 | 0 = falling/low, 1 = rising/high |
| fast_clr | input | 1 | Read clears the slot flag |
| irq_en | input | 1 | Interrupt enable |
| len_sel | input | 2 | Sequence length code |
| seq_wr | input | 1 | Sequence word write strobe |
| seq_multi | input | 1 | Step through channels |
| seq_scan | input | 1 | Continuous scan |
| seq_chan | input | CH_W | Starting channel code |
| trig_pin | input | 1 | External trigger pin (asynchronous) |
| conv_start | output | 1 | Start request to the engine |
| conv_chan | output | CH_W | Channel for the current conversion |
| conv_done | input | 1 | Engine result valid pulse |
| conv_data | input | RES_W | Engine result |
| rd_en | input | 1 | Result read strobe |
| rd_slot | input | 3 | Slot being read |
| rd_data | output | RES_W | Contents of slot `rd_slot` |
| cc_flags | output | 8 | Per-slot completion flags |
| seq_done | output | 1 | Sequence complete |
| irq | output | 1 | Interrupt |

## Verification
A modelled engine answers every request after a fixed delay, with data derived from the channel. At every start the bench predicts the channel and the slot, so stepping, wrapping and fixed-channel runs are compared conversion by conversion. Sequence lengths of 1, 4 and 8 are run from writes. The starting codes are picked so that some slots fall beyond the last real channel and others wrap past 15 back to 0, which exposes zero-forcing and wrap errors. In trigger mode the bench applies both edges under both polarities and checks the exact start cycle, which tells the edge modes apart. Holding and releasing the pin in level mode, and ending scan in each of its four ways, tells a run that stops from one that keeps going.

// File: rtl/adc_seq_pkg.sv
// Shared types and helpers for the conversion sequence controller.
// Assumes at most eight result slots, the longest selectable sequence.
package adc_seq_pkg;
    localparam int SLOTS  = 8;
    localparam int SLOT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    // Map the length code to a conversion count (00:4, 01:1, others:8).
    function automatic logic [SLOT_W:0] len_decode(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd4;
            2'b01:   return 4'd1;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/adc_trig_detect.sv
// Synchronizes the external trigger pin with two flops and derives an
// edge event and a level-active indication for the selected polarity.
// Assumes the pin is asynchronous to clk.
module adc_trig_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic edge_evt,
    output logic lvl_act
);
    logic s1_q, s2_q, prev_q;

    // Two-stage synchronizer plus a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Polarity selects which transition or level counts as active.
    always_comb begin
        edge_evt = pol ? (s2_q & ~prev_q) : (~s2_q & prev_q);
        lvl_act  = pol ? s2_q : ~s2_q;
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencer: decides when sequences start, walks the slots, issues
// one-cycle start requests with a channel and reports slot writes.
// Assumes the engine answers each request with one conv_done pulse.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              power_up,
    input  logic              halt_req,
    input  logic              seq_wr,
    input  logic              seq_multi,
    input  logic              seq_scan,
    input  logic [CH_W-1:0]   seq_chan,
    input  logic [1:0]        len_sel,
    input  logic              trig_en,
    input  logic              trig_level,
    input  logic              edge_evt,
    input  logic              lvl_act,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic              new_seq,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              wr_last
);
    seq_state_t        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CH_W-1:0]   base_q;
    logic              multi_q, scan_q;
    logic [SLOT_W:0]   len_q;

    logic abort, wr_start, trig_start, keep_going;

    // Start, abort and continuation decisions.
    always_comb begin
        abort      = clr | ~power_up | halt_req;
        wr_start   = seq_wr & power_up & ~trig_en;
        trig_start = trig_en & power_up & (state_q == ST_IDLE)
                   & (trig_level ? lvl_act : edge_evt);
        new_seq    = (wr_start | trig_start) & ~abort;
        keep_going = trig_en ? (trig_level & lvl_act) : scan_q;
    end

    // Outputs toward the engine and the result bank.
    always_comb begin
        conv_start = (state_q == ST_ISSUE);
        conv_chan  = multi_q ? (base_q + CH_W'(slot_q)) : base_q;
        wr_en      = (state_q == ST_WAIT) & conv_done & ~abort & ~new_seq;
        wr_slot    = slot_q;
        wr_last    = ({1'b0, slot_q} == (len_q - 1'b1));
    end

    // Latch the sequence word on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            base_q  <= '0;
            multi_q <= 1'b0;
            scan_q  <= 1'b0;
            len_q   <= len_decode(2'b00);
        end else if (seq_wr && power_up) begin
            base_q  <= seq_chan;
            multi_q <= seq_multi;
            scan_q  <= seq_scan;
            len_q   <= len_decode(len_sel);
        end else if (abort) begin
            scan_q  <= 1'b0;
        end
    end

    // State and slot progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else if (new_seq) begin
            state_q <= ST_ISSUE;
            slot_q  <= '0;
        end else begin
            case (state_q)
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (conv_done) begin
                    if (wr_last) begin
                        slot_q  <= '0;
                        state_q <= keep_going ? ST_ISSUE : ST_IDLE;
                    end else begin
                        slot_q  <= slot_q + 1'b1;
                        state_q <= ST_ISSUE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R12
    power_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !power_up |=> !conv_start);
    // R3
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_slot} < len_q));
endmodule

// File: rtl/adc_result_bank.sv
// Result slots with per-slot completion flags and the sequence-complete
// flag. Assumes a start and a slot write never arrive in the same cycle.
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              new_seq,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic              wr_last,
    input  logic [RES_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic              fast_clr,
    output logic [RES_W-1:0]  rd_data,
    output logic [SLOTS-1:0]  cc_flags,
    output logic              seq_done
);
    logic [RES_W-1:0] data_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic hit_wr, hit_rd;
        assign hit_wr = wr_en && (wr_slot == SLOT_W'(i));
        assign hit_rd = rd_en && fast_clr && (rd_slot == SLOT_W'(i));

        // Slot storage; invalid channels store zero.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)  data_q[i] <= '0;
            else if (hit_wr)    data_q[i] <= wr_valid ? wr_data : '0;
        end

        // Slot flag: a write sets it, a start or a fast-clear read clears it.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)  cc_flags[i] <= 1'b0;
            else if (hit_wr)    cc_flags[i] <= 1'b1;
            else if (new_seq)   cc_flags[i] <= 1'b0;
            else if (hit_rd)    cc_flags[i] <= 1'b0;
        end
    end

    // Sequence-complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          seq_done <= 1'b0;
        else if (wr_en && wr_last)  seq_done <= 1'b1;
        else if (new_seq)           seq_done <= 1'b0;
    end

    assign rd_data = data_q[rd_slot];

    // R5
    invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid && !clr) |=> (data_q[$past(wr_slot)] == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the conversion trigger and sequence controller: trigger
// detection, sequencer and result bank. Assumes a single clock domain
// except for trig_pin.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CH_W   = 4,
    parameter int NUM_CH = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_up,
    input  logic              halt_req,
    input  logic              soft_rst,
    input  logic              trig_en,
    input  logic              trig_level,
    input  logic              trig_pol,
    input  logic              fast_clr,
    input  logic              irq_en,
    input  logic [1:0]        len_sel,
    input  logic              seq_wr,
    input  logic              seq_multi,
    input  logic              seq_scan,
    input  logic [CH_W-1:0]   seq_chan,
    input  logic              trig_pin,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [RES_W-1:0]  rd_data,
    output logic [SLOTS-1:0]  cc_flags,
    output logic              seq_done,
    output logic              irq
);
    localparam logic [CH_W:0] CH_LIMIT = (CH_W + 1)'(NUM_CH);

    logic edge_evt, lvl_act, new_seq, wr_en, wr_last, wr_valid;
    logic [SLOT_W-1:0] wr_slot;

    adc_trig_detect u_trig (
        .clk(clk), .rst_n(rst_n), .pin(trig_pin), .pol(trig_pol),
        .edge_evt(edge_evt), .lvl_act(lvl_act)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .power_up(power_up),
        .halt_req(halt_req), .seq_wr(seq_wr), .seq_multi(seq_multi),
        .seq_scan(seq_scan), .seq_chan(seq_chan), .len_sel(len_sel),
        .trig_en(trig_en), .trig_level(trig_level), .edge_evt(edge_evt),
        .lvl_act(lvl_act), .conv_done(conv_done), .conv_start(conv_start),
        .conv_chan(conv_chan), .new_seq(new_seq), .wr_en(wr_en),
        .wr_slot(wr_slot), .wr_last(wr_last)
    );

    // A channel code past the last real input converts to zero.
    assign wr_valid = ({1'b0, conv_chan} < CH_LIMIT);

    adc_result_bank #(.RES_W(RES_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .new_seq(new_seq),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_valid(wr_valid),
        .wr_last(wr_last), .wr_data(conv_data), .rd_en(rd_en),
        .rd_slot(rd_slot), .fast_clr(fast_clr), .rd_data(rd_data),
        .cc_flags(cc_flags), .seq_done(seq_done)
    );

    // Interrupt follows the sequence-complete flag when enabled.
    assign irq = seq_done & irq_en;

    // R10
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(conv_done));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, power_up, halt_req, soft_rst, trig_en, trig_level, trig_pol;
    logic fast_clr, irq_en, seq_wr, seq_multi, seq_scan, trig_pin;
    logic [1:0] len_sel;
    logic [3:0] seq_chan, conv_chan;
    logic conv_start, conv_done, rd_en, seq_done, irq;
    logic [9:0] conv_data, rd_data;
    logic [2:0] rd_slot;
    logic [7:0] cc_flags;

    int checks = 0, failures = 0, cycles = 0, n_starts = 0;
    int exp_base = 0, exp_multi = 0, exp_len = 4, exp_idx = 0;
    int exp_res [8];
    int eng_cnt = 0, eng_chan = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .power_up(power_up), .halt_req(halt_req),
        .soft_rst(soft_rst), .trig_en(trig_en), .trig_level(trig_level),
        .trig_pol(trig_pol), .fast_clr(fast_clr), .irq_en(irq_en),
        .len_sel(len_sel), .seq_wr(seq_wr), .seq_multi(seq_multi),
        .seq_scan(seq_scan), .seq_chan(seq_chan), .trig_pin(trig_pin),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .rd_en(rd_en), .rd_slot(rd_slot),
        .rd_data(rd_data), .cc_flags(cc_flags), .seq_done(seq_done), .irq(irq)
    );

    function automatic int chan_result(int ch);
        return (ch < 12) ? ch * 50 + 7 : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Engine model plus per-start channel/slot prediction.
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                conv_done <= 1'b1;
                conv_data <= 10'(eng_chan * 50 + 7);
            end
        end
        if (conv_start) begin
            int ch;
            ch = exp_multi ? (exp_base + exp_idx) % 16 : exp_base;
            chk(int'(conv_chan) == ch, "R4 channel", int'(conv_chan), ch);
            exp_res[exp_idx] = chan_result(ch);
            exp_idx = (exp_idx + 1) % exp_len;
            n_starts++;
            eng_chan = int'(conv_chan);
            eng_cnt = 3;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_seq(input int ch, input bit multi, input bit scan, input logic [1:0] ls);
        @(negedge clk);
        seq_chan = 4'(ch); seq_multi = multi; seq_scan = scan; len_sel = ls; seq_wr = 1'b1;
        exp_base = ch; exp_multi = multi; exp_idx = 0;
        exp_len = (ls == 2'b00) ? 4 : (ls == 2'b01) ? 1 : 8;
        @(negedge clk);
        seq_wr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!seq_done && n < 500) begin @(negedge clk); n++; end
        chk(seq_done == 1'b1, req, int'(seq_done), 1);
    endtask

    task automatic check_slots(input string req);
        for (int i = 0; i < exp_len; i++) begin
            rd_slot = 3'(i);
            #1;
            chk(int'(rd_data) == exp_res[i], req, int'(rd_data), exp_res[i]);
        end
    endtask

    task automatic expect_stopped(input string req);
        int n0;
        tick(30);
        n0 = n_starts;
        tick(30);
        chk(n_starts == n0, req, n_starts, n0);
    endtask

    initial begin
        int n0;
        rst_n = 0; power_up = 0; halt_req = 0; soft_rst = 0; trig_en = 0;
        trig_level = 0; trig_pol = 0; fast_clr = 0; irq_en = 0; seq_wr = 0;
        seq_multi = 0; seq_scan = 0; trig_pin = 1; len_sel = 0; seq_chan = 0;
        rd_en = 0; rd_slot = 0; conv_data = 0; conv_done = 0;
        tick(4);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk(cc_flags == 8'h00, "R1 cc_flags", int'(cc_flags), 0);
        chk(seq_done == 1'b0, "R1 seq_done", int'(seq_done), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(conv_start == 1'b0, "R1 conv_start", int'(conv_start), 0);

        // R12 powered down: writes start nothing
        write_seq(3, 0, 0, 2'b00);
        tick(20);
        chk(n_starts == 0, "R12 no start when down", n_starts, 0);

        // R2/R3/R4 single channel, default length
        power_up = 1; irq_en = 1;
        write_seq(3, 0, 0, 2'b00);
        chk(conv_start == 1'b1, "R2 start after write", int'(conv_start), 1);
        tick(1);
        chk(conv_start == 1'b0, "R2 one-cycle pulse", int'(conv_start), 0);
        wait_done("R3 len4 done");
        chk(cc_flags == 8'h0F, "R3 len4 flags", int'(cc_flags), 15);
        check_slots("R4 fixed channel data");
        chk(irq == 1'b1, "R11 irq on", int'(irq), 1);
        irq_en = 0; #1;
        chk(irq == 1'b0, "R11 irq masked", int'(irq), 0);

        // R4/R5 multi-channel length 8, wrap and invalid codes
        write_seq(10, 1, 0, 2'b10);
        wait_done("R3 len8 done");
        chk(cc_flags == 8'hFF, "R3 len8 flags", int'(cc_flags), 255);
        check_slots("R4 stepped data");
        rd_slot = 3'd2; #1;
        chk(rd_data == 10'd0, "R5 invalid code zero", int'(rd_data), 0);
        rd_slot = 3'd6; #1;
        chk(int'(rd_data) == 7, "R4 wrap to channel 0", int'(rd_data), 7);

        // R3/R10 length 1; start clears old flags
        write_seq(7, 0, 0, 2'b01);
        tick(1);
        chk(cc_flags == 8'h00, "R10 start clears flags", int'(cc_flags), 0);
        wait_done("R3 len1 done");
        chk(cc_flags == 8'h01, "R3 len1 flags", int'(cc_flags), 1);
        check_slots("R4 len1 data");

        // R10 reads with and without fast clear
        rd_slot = 0; rd_en = 1; tick(1); rd_en = 0; tick(1);
        chk(cc_flags == 8'h01, "R10 read no clear", int'(cc_flags), 1);
        fast_clr = 1; rd_en = 1; tick(1); rd_en = 0; tick(1);
        chk(cc_flags == 8'h00, "R10 fast clear", int'(cc_flags), 0);
        fast_clr = 0;

        // R12 retention over power cycle
        write_seq(4, 0, 0, 2'b00);
        wait_done("R12 seq done");
        tick(5);
        power_up = 0; tick(2); power_up = 1; tick(2);
        chk(cc_flags == 8'h0F, "R12 flags retained", int'(cc_flags), 15);
        rd_slot = 0; #1;
        chk(int'(rd_data) == 207, "R12 data retained", int'(rd_data), 207);

        // R9 scan and its four stop conditions
        write_seq(1, 0, 1, 2'b01);
        n0 = n_starts; tick(40);
        chk(n_starts > n0 + 3, "R9 scan repeats", n_starts, n0 + 4);
        halt_req = 1; tick(1); halt_req = 0;
        expect_stopped("R9 halt stops scan");
        write_seq(1, 0, 1, 2'b01);
        tick(20);
        write_seq(1, 0, 0, 2'b01);
        expect_stopped("R9 non-scan write stops");
        write_seq(1, 0, 1, 2'b01);
        tick(20);
        power_up = 0; tick(1); power_up = 1;
        expect_stopped("R9 power down stops");
        write_seq(1, 0, 1, 2'b01);
        tick(20);
        soft_rst = 1; tick(1); soft_rst = 0;
        expect_stopped("R13 soft reset stops");
        chk(cc_flags == 8'h00, "R13 flags cleared", int'(cc_flags), 0);
        chk(seq_done == 1'b0, "R13 done cleared", int'(seq_done), 0);
        rd_slot = 0; #1;
        chk(rd_data == 10'd0, "R13 data cleared", int'(rd_data), 0);

        // R6/R7 falling-edge trigger
        trig_en = 1; trig_level = 0; trig_pol = 0;
        tick(5);
        n0 = n_starts;
        write_seq(2, 0, 0, 2'b01);
        tick(20);
        chk(n_starts == n0, "R6 write ignored", n_starts, n0);
        trig_pin = 0;
        tick(1); chk(conv_start == 1'b0, "R7 latency c1", int'(conv_start), 0);
        tick(1); chk(conv_start == 1'b0, "R7 latency c2", int'(conv_start), 0);
        tick(1); chk(conv_start == 1'b1, "R7 start third cycle", int'(conv_start), 1);
        wait_done("R7 edge seq done");
        check_slots("R7 edge data");
        n0 = n_starts;
        trig_pin = 1; tick(20);
        chk(n_starts == n0, "R7 rising ignored", n_starts, n0);
        // R7 rising-edge mode
        trig_pol = 1; tick(2);
        trig_pin = 0; tick(20);
        chk(n_starts == n0, "R7 falling ignored", n_starts, n0);
        trig_pin = 1; tick(20);
        chk(n_starts == n0 + 1, "R7 rising one seq", n_starts, n0 + 1);

        // R8 level modes
        trig_level = 1; trig_pol = 1;
        n0 = n_starts; tick(40);
        chk(n_starts > n0 + 3, "R8 high level runs", n_starts, n0 + 4);
        trig_pin = 0;
        expect_stopped("R8 high level stops");
        trig_pol = 0;
        n0 = n_starts; tick(40);
        chk(n_starts > n0 + 3, "R8 low level runs", n_starts, n0 + 4);
        trig_pin = 1;
        expect_stopped("R8 low level stops");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule